// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting (8,4) Block Codec

This block holds two independent channels that share a code: an encoder that turns a 4-bit message into an 8-bit protected word, and a decoder that takes an 8-bit word back from the channel, removes any single flipped bit and reports any pair of flipped bits. Each parity bit is the XOR of three of the four message bits, and a different message bit is left out of each one. This layout gives a code of minimum distance 4. Every single-bit error has a syndrome of odd weight, every double-bit error has one of even weight, so one pass through the decoder tells the two cases apart.

Both channels use a valid/ready handshake on their input and output. Each channel has a single output register, so a result appears one cycle after its input is accepted. The result stays frozen while the downstream side holds ready low. The message sits unchanged in the high nibble of the codeword, so a consumer that does not need checking can read the data without decoding.

Top module: `secdedCodec`

## Requirements
- R1: The encoder codeword is {m3,m2,m1,m0,p3,p2,p1,p0} from bit 7 down to bit 0, where p0 = m1^m2^m3, p1 = m0^m1^m2, p2 = m0^m1^m3 and p3 = m0^m2^m3.
- R2: A message accepted by the encoder appears on the encoder output with valid high on the next clock edge. It stays valid and unchanged for as long as the encoder's output ready is low.
- R3: A received word that is a valid codeword gives its high nibble as the message, with both flags low.
- R4: A received word with exactly one flipped bit among bits 7..4 gives the original message with that bit restored. The corrected flag goes high and the uncorrectable flag stays low.
- R5: A received word with exactly one flipped bit among bits 3..0 gives the unchanged high nibble as the message, with the corrected flag high and the uncorrectable flag low.
- R6: A received word with exactly two flipped bits raises the uncorrectable flag and lowers the corrected flag. Its message output equals the received high nibble, unmodified.
- R7: A word accepted by the decoder appears on the decoder output with valid high on the next clock edge. It stays valid, with message and flags unchanged, for as long as the decoder's output ready is low.
- R8: After reset, both output valids are low and both input readies are high.
- R9: Each channel's input ready is high exactly when its output register is empty or its output ready is high. While its input ready is low, offered input is not taken.
- R10: The corrected and uncorrectable flags are never both high on a valid decoder output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| encInValid | input | 1 | Encoder input message is offered |
| encInReady | output | 1 | Encoder can take a message |
| encMsg | input | 4 | Message to protect |
| encOutValid | output | 1 | Codeword output is valid |
| encOutReady | input | 1 | Downstream takes the codeword |
| encCode | output | 8 | Protected codeword |
| decInValid | input | 1 | Decoder input word is offered |
| decInReady | output | 1 | Decoder can take a word |
| decWord | input | 8 | Word received from the channel |
| decOutValid | output | 1 | Decoder result is valid |
| decOutReady | input | 1 | Downstream takes the result |
| decMsg | output | 4 | Recovered message |
| decCorrected | output | 1 | One bit was flipped and has been repaired |
| decUncorrectable | output | 1 | Two bits were flipped; message left as received |

## Verification
The encoder is driven with all sixteen messages. This separates a wrong coverage mask on any parity bit from a swapped nibble. The decoder is driven with every clean codeword, with every one of the eight single-bit flips on two messages, and with all 28 two-bit flips. The single flips tell a message-bit repair apart from a parity-bit repair. The two-bit flips show that even-weight syndromes are never mistaken for a column match. Backpressure runs on each channel check that results are held and that input is refused while the output slot is full.

// File: rtl/secdedPkg.sv
package secdedPkg;
  localparam int MSG_W  = 4;
  localparam int PAR_W  = 4;
  localparam int CODE_W = MSG_W + PAR_W;
  localparam int CHAN_N = 2;   // channel 0 = encoder, channel 1 = decoder

  // Coverage of each parity bit over the message bits (row i -> parity i).
  localparam logic [PAR_W-1:0][MSG_W-1:0] PAR_MASK = {
    4'b1101,   // p3
    4'b1011,   // p2
    4'b0111,   // p1
    4'b1110    // p0
  };

  typedef struct packed {
    logic encLoad;
    logic decLoad;
  } ctlStrobe_t;

  function automatic logic [PAR_W-1:0] parityOf(input logic [MSG_W-1:0] msg);
    logic [PAR_W-1:0] par;
    for (int i = 0; i < PAR_W; i++) par[i] = ^(msg & PAR_MASK[i]);
    return par;
  endfunction
endpackage

// File: rtl/secdedControl.sv
module secdedControl
  import secdedPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAN_N-1:0] inValid,
  input  logic [CHAN_N-1:0] outReady,
  output logic [CHAN_N-1:0] inReady,
  output logic [CHAN_N-1:0] outValid,
  output ctlStrobe_t        strobe
);
  logic [CHAN_N-1:0] load;

  for (genvar ch = 0; ch < CHAN_N; ch++) begin : gChan
    logic validQ;
    assign inReady[ch]  = !validQ || outReady[ch];
    assign load[ch]     = inValid[ch] && inReady[ch];
    assign outValid[ch] = validQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            validQ <= 1'b0;
      else if (inReady[ch]) validQ <= inValid[ch];
    end
  end

  assign strobe.encLoad = load[0];
  assign strobe.decLoad = load[1];
endmodule

// File: rtl/secdedDatapath.sv
module secdedDatapath
  import secdedPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [MSG_W-1:0]  encMsg,
  input  logic [CODE_W-1:0] decWord,
  output logic [CODE_W-1:0] encCode,
  output logic [MSG_W-1:0]  decMsg,
  output logic              decCorrected,
  output logic              decUncorrectable
);
  logic [MSG_W-1:0] rxMsg;
  logic [PAR_W-1:0] rxPar;
  logic [PAR_W-1:0] syndrome;
  logic [MSG_W-1:0] colHit;
  logic             parHit;
  logic             singleErr;
  logic             doubleErr;
  logic [MSG_W-1:0] fixedMsg;

  assign rxMsg    = decWord[CODE_W-1:PAR_W];
  assign rxPar    = decWord[PAR_W-1:0];
  assign syndrome = rxPar ^ parityOf(rxMsg);

  // Column of the check matrix for each message bit, derived from the masks.
  for (genvar j = 0; j < MSG_W; j++) begin : gCol
    localparam logic [MSG_W-1:0] UNIT = MSG_W'(1 << j);
    assign colHit[j] = (syndrome == parityOf(UNIT));
  end

  assign parHit    = $onehot(syndrome);
  assign singleErr = parHit || (|colHit);
  assign doubleErr = (syndrome != '0) && !singleErr;
  assign fixedMsg  = doubleErr ? rxMsg : (rxMsg ^ colHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      encCode          <= '0;
      decMsg           <= '0;
      decCorrected     <= 1'b0;
      decUncorrectable <= 1'b0;
    end else begin
      if (strobe.encLoad) encCode <= {encMsg, parityOf(encMsg)};
      if (strobe.decLoad) begin
        decMsg           <= fixedMsg;
        decCorrected     <= singleErr;
        decUncorrectable <= doubleErr;
      end
    end
  end
endmodule

// File: rtl/secdedCodec.sv
module secdedCodec
  import secdedPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              encInValid,
  output logic              encInReady,
  input  logic [MSG_W-1:0]  encMsg,
  output logic              encOutValid,
  input  logic              encOutReady,
  output logic [CODE_W-1:0] encCode,
  input  logic              decInValid,
  output logic              decInReady,
  input  logic [CODE_W-1:0] decWord,
  output logic              decOutValid,
  input  logic              decOutReady,
  output logic [MSG_W-1:0]  decMsg,
  output logic              decCorrected,
  output logic              decUncorrectable
);
  ctlStrobe_t        strobe;
  logic [CHAN_N-1:0] inReadyV;
  logic [CHAN_N-1:0] outValidV;

  secdedControl ctl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  ({decInValid, encInValid}),
    .outReady ({decOutReady, encOutReady}),
    .inReady  (inReadyV),
    .outValid (outValidV),
    .strobe   (strobe)
  );

  secdedDatapath dp (
    .clk              (clk),
    .rstN             (rstN),
    .strobe           (strobe),
    .encMsg           (encMsg),
    .decWord          (decWord),
    .encCode          (encCode),
    .decMsg           (decMsg),
    .decCorrected     (decCorrected),
    .decUncorrectable (decUncorrectable)
  );

  assign encInReady  = inReadyV[0];
  assign decInReady  = inReadyV[1];
  assign encOutValid = outValidV[0];
  assign decOutValid = outValidV[1];
endmodule

// File: rtl/secdedChecker.sv
module secdedChecker
  import secdedPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              encInValid,
  input logic              encInReady,
  input logic [MSG_W-1:0]  encMsg,
  input logic              encOutValid,
  input logic              encOutReady,
  input logic [CODE_W-1:0] encCode,
  input logic              decInValid,
  input logic              decInReady,
  input logic              decOutValid,
  input logic              decOutReady,
  input logic [MSG_W-1:0]  decMsg,
  input logic              decCorrected,
  input logic              decUncorrectable
);
  logic [CODE_W-1:0] expCode;
  assign expCode = {encMsg,
                    encMsg[0] ^ encMsg[2] ^ encMsg[3],
                    encMsg[0] ^ encMsg[1] ^ encMsg[3],
                    encMsg[0] ^ encMsg[1] ^ encMsg[2],
                    encMsg[1] ^ encMsg[2] ^ encMsg[3]};

  AST_ENC_CODEWORD: assert property (@(posedge clk) disable iff (!rstN)
    encInValid && encInReady |=> encCode == $past(expCode)); // R1
  AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    encInValid && encInReady |=> encOutValid); // R2
  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    encOutValid && !encOutReady |=> encOutValid && $stable(encCode)); // R2
  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    decInValid && decInReady |=> decOutValid); // R7
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    decOutValid && !decOutReady |=> decOutValid && $stable(decMsg)
      && $stable(decCorrected) && $stable(decUncorrectable)); // R7
  AST_ENC_READY: assert property (@(posedge clk) disable iff (!rstN)
    encInReady == (!encOutValid || encOutReady)); // R9
  AST_DEC_READY: assert property (@(posedge clk) disable iff (!rstN)
    decInReady == (!decOutValid || decOutReady)); // R9
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    decOutValid |-> !(decCorrected && decUncorrectable)); // R10
endmodule

bind secdedCodec secdedChecker chk (.*);

// File: tb/secdedCodec_test.sv
module secdedCodec_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       encInValid = 1'b0, encOutReady = 1'b1;
  logic [3:0] encMsg = '0;
  logic       decInValid = 1'b0, decOutReady = 1'b1;
  logic [7:0] decWord = '0;
  logic       encInReady, encOutValid, decInReady, decOutValid;
  logic [7:0] encCode;
  logic [3:0] decMsg;
  logic       decCorrected, decUncorrectable;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;   // 250 MHz

  secdedCodec uut (.*);

  function automatic logic [7:0] refCode(input logic [3:0] m);
    return {m, m[0]^m[2]^m[3], m[0]^m[1]^m[3], m[0]^m[1]^m[2], m[1]^m[2]^m[3]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic testReset();
    check(!encOutValid && !decOutValid, "R8 out valids", {6'd0, encOutValid, decOutValid}, 8'h00);
    check(encInReady && decInReady, "R8 in readies", {6'd0, encInReady, decInReady}, 8'h03);
  endtask

  task automatic encodeOne(input logic [3:0] m);
    @(negedge clk); encInValid = 1'b1; encMsg = m; encOutReady = 1'b1;
    @(posedge clk); #1;
    check(encOutValid, "R2 enc latency", {7'd0, encOutValid}, 8'h01);
    check(encCode == refCode(m), "R1 codeword", encCode, refCode(m));
    @(negedge clk); encInValid = 1'b0;
  endtask

  task automatic testEncodeAll();
    for (int m = 0; m < 16; m++) encodeOne(4'(m));
  endtask

  task automatic testEncodeStall();
    @(negedge clk); encInValid = 1'b1; encMsg = 4'hA; encOutReady = 1'b0;
    @(negedge clk); encMsg = 4'h5;   // offered while slot full
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      check(encOutValid && encCode == refCode(4'hA), "R2 enc hold", encCode, refCode(4'hA));
      check(!encInReady, "R9 enc not ready", {7'd0, encInReady}, 8'h00);
    end
    @(negedge clk); encOutReady = 1'b1;
    #0 check(encInReady, "R9 enc ready on drain", {7'd0, encInReady}, 8'h01);
    @(posedge clk); #1;
    check(encCode == refCode(4'h5), "R9 enc second accepted", encCode, refCode(4'h5));
    @(negedge clk); encInValid = 1'b0;
    @(posedge clk); #1;
    check(!encOutValid, "R2 enc drained", {7'd0, encOutValid}, 8'h00);
  endtask

  task automatic decodeOne(input logic [7:0] w, input logic [3:0] em, input bit ec,
                           input bit eu, input string req);
    @(negedge clk); decInValid = 1'b1; decWord = w; decOutReady = 1'b1;
    @(posedge clk); #1;
    check(decOutValid && decMsg == em && decCorrected == ec && decUncorrectable == eu,
          req, {decOutValid, decCorrected, decUncorrectable, 1'b0, decMsg},
          {1'b1, ec, eu, 1'b0, em});
    check(!(decCorrected && decUncorrectable), "R10 flags exclusive",
          {6'd0, decCorrected, decUncorrectable}, 8'h00);
    @(negedge clk); decInValid = 1'b0;
  endtask

  task automatic testDecodeClean();
    for (int m = 0; m < 16; m++) decodeOne(refCode(4'(m)), 4'(m), 1'b0, 1'b0, "R3 clean");
  endtask

  task automatic testDecodeSingle();
    logic [3:0] msgs [2] = '{4'h6, 4'hD};
    foreach (msgs[k]) begin
      for (int p = 0; p < 8; p++) begin
        if (p >= 4) decodeOne(refCode(msgs[k]) ^ (8'd1 << p), msgs[k], 1'b1, 1'b0, "R4 msg bit flip");
        else        decodeOne(refCode(msgs[k]) ^ (8'd1 << p), msgs[k], 1'b1, 1'b0, "R5 parity bit flip");
      end
    end
  endtask

  task automatic testDecodeDouble();
    logic [7:0] w;
    for (int a = 0; a < 8; a++)
      for (int b = a + 1; b < 8; b++) begin
        w = refCode(4'h9) ^ (8'd1 << a) ^ (8'd1 << b);
        decodeOne(w, w[7:4], 1'b0, 1'b1, "R6 double flip");
      end
  endtask

  task automatic testDecodeStall();
    logic [7:0] w;
    w = refCode(4'h3) ^ 8'h20;
    @(negedge clk); decInValid = 1'b1; decWord = w; decOutReady = 1'b0;
    @(negedge clk); decWord = refCode(4'hC);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      check(decOutValid && decMsg == 4'h3 && decCorrected, "R7 dec hold",
            {decOutValid, decCorrected, 2'b0, decMsg}, 8'hC3);
      check(!decInReady, "R9 dec not ready", {7'd0, decInReady}, 8'h00);
    end
    @(negedge clk); decOutReady = 1'b1;
    @(posedge clk); #1;
    check(decMsg == 4'hC && !decCorrected, "R7 dec next result", {3'd0, decCorrected, decMsg}, 8'h0C);
    @(negedge clk); decInValid = 1'b0;
    @(posedge clk); #1;
    check(!decOutValid, "R7 dec drained", {7'd0, decOutValid}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 testReset();
    @(negedge clk); rstN = 1'b1;
    testEncodeAll();
    testEncodeStall();
    testDecodeClean();
    testDecodeSingle();
    testDecodeDouble();
    testDecodeStall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule